// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a synchronous request port and an external asynchronous static RAM of 128K bytes (17 address bits, 8 data bits). It takes one request at a time, either a single-byte read or a single-byte write, and plays it out on the memory pins. The strobes are timed by cycle counts that are worked out at elaboration from nanosecond timing figures and a clock-period parameter. Every memory-side output comes straight from a flop, so the strobes do not glitch. The address is loaded only at the moment the chip goes from deselected to selected.

A read selects the chip with output enable low. It holds that state for the access count and captures the byte on the final cycle. It then deselects the chip and returns the byte with a one-cycle response strobe. A write selects the chip with output enable held high for the whole access, so no bus turnaround is needed. It spends one setup cycle driving the data with write enable still high, then pulls write enable low for the pulse count. It raises write enable and turns the data driver off together, spends one more cycle still selected, and then deselects. The chip is deselected for at least one cycle between any two requests. The byte bus is split into an outgoing value, an incoming value and a driver enable, so the pad ring can build the tristate.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, with no request pending: mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: A read is accepted on a clock edge where req_valid=1 and req_wr=0. From that edge the chip is selected (mem_ce1_n=0, mem_ce2=1) with mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. The byte on mem_dq_i in the last of those cycles is returned on rsp_rdata, with rsp_valid high, in the first cycle after the chip is deselected.
- R3: A write is accepted on a clock edge where req_valid=1 and req_wr=1. It keeps mem_oe_n=1 throughout. It gives one selected cycle with mem_we_n=1, then WP_CYC cycles with mem_we_n=0, then one selected cycle with mem_we_n=1, then deselects. rsp_valid pulses in the first deselected cycle.
- R4: mem_dq_oe is high only while the chip is selected for a write with mem_oe_n=1. It covers the setup cycle and every cycle with mem_we_n=0. It drops on the same edge where mem_we_n rises. mem_dq_o holds the request's write byte and does not change while mem_dq_oe is high.
- R5: mem_addr changes only on an edge where the chip was deselected beforehand. A request presented while req_ready=0 is ignored, and the access in progress is not changed.
- R6: rsp_valid is high for exactly one cycle per accepted request. req_ready is high only while the chip is deselected and the controller is idle.
- R7: Cycle counts are ceil(ns / CLK_NS), each at least 1. RD_CYC is the larger of the read-cycle and address-access counts. WP_CYC is the largest of the pulse-width count, the data-setup count, and the write-cycle count minus 2. With the defaults (10 ns clock, 55/55/55/40/25 ns) the response arrives on the seventh cycle after acceptance for both reads and writes.
- R8: All 17 address bits and all 8 data bits pass through unchanged, including addresses 17'h00000 and 17'h1FFFF and bytes 8'h00 and 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Byte driven towards the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 8 | Byte read from the memory bus |

## Verification
The assertions check the pin rules on every cycle. Write enable and output enable are never low together. The data driver is on only during a selected write with output enable high, and its byte stays fixed while it is on. The address stays fixed while the chip stays selected. Each write-enable pulse lasts at least the computed count. The response is a one-cycle strobe, and ready is never high while the chip is selected. Only the bench's scenarios can show that the right byte reaches the right location and comes back. Its RAM model releases valid read data only once the access time has passed, and checks pulse width, data setup, write-cycle length and address stability in nanoseconds. The same scenarios also show the exact response latency, and that a request held during a busy access is dropped.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    // ns figure to whole clock periods, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WSET  = 3'd2,
        ST_WPULS = 3'd3,
        ST_WREC  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/asram_down_cnt.sv
`timescale 1ns/1ps
module asram_down_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_cap.sv
`timescale 1ns/1ps
module asram_rd_cap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          wr_done,
    input  logic [DW-1:0] dq_i,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = cap_en | wr_done;
        if (cap_en) begin
            cap_d.data = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_rdata = cap_q.data;
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 6,
    parameter int WP_CYC = 4,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic          cnt_zero,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          cap_en,
    output logic          wr_done,
    output logic          sel,
    output logic          oe_n,
    output logic          we_n,
    output logic          drv,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        seq_state_e    st;
        logic          sel;
        logic          oe_n;
        logic          we_n;
        logic          drv;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, sel: 1'b0, oe_n: 1'b1,
                                 we_n: 1'b1, drv: 1'b0, addr: '0, wdata: '0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cap_en   = 1'b0;
        wr_done  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    seq_d.sel  = 1'b1;
                    if (req_wr) begin
                        seq_d.wdata = req_wdata;
                        seq_d.drv   = 1'b1;
                        seq_d.st    = ST_WSET;
                    end else begin
                        seq_d.oe_n = 1'b0;
                        cnt_load   = 1'b1;
                        cnt_val    = CW'(RD_CYC - 1);
                        seq_d.st   = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    cap_en     = 1'b1;
                    seq_d.sel  = 1'b0;
                    seq_d.oe_n = 1'b1;
                    seq_d.st   = ST_IDLE;
                end
            end
            ST_WSET: begin
                seq_d.we_n = 1'b0;
                cnt_load   = 1'b1;
                cnt_val    = CW'(WP_CYC - 1);
                seq_d.st   = ST_WPULS;
            end
            ST_WPULS: begin
                if (cnt_zero) begin
                    seq_d.we_n = 1'b1;
                    seq_d.drv  = 1'b0;
                    seq_d.st   = ST_WREC;
                end
            end
            ST_WREC: begin
                wr_done   = 1'b1;
                seq_d.sel = 1'b0;
                seq_d.st  = ST_IDLE;
            end
            default: begin
                seq_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign sel       = seq_q.sel;
    assign oe_n      = seq_q.oe_n;
    assign we_n      = seq_q.we_n;
    assign drv       = seq_q.drv;
    assign addr      = seq_q.addr;
    assign wdata     = seq_q.wdata;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 40,
    parameter int T_DW_NS = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int RD_CYC = imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
    localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_WC_NS, CLK_NS) - 2, 1));
    localparam int CW     = $clog2(imax(RD_CYC, WP_CYC) + 1);

    logic          cnt_zero;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cap_en;
    logic          wr_done;
    logic          sel;

    asram_seq #(
        .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CW(CW)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cap_en    (cap_en),
        .wr_done   (wr_done),
        .sel       (sel),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .drv       (mem_dq_oe),
        .addr      (mem_addr),
        .wdata     (mem_dq_o)
    );

    asram_down_cnt #(.CW(CW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    asram_rd_cap #(.DW(DW)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .wr_done   (wr_done),
        .dq_i      (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // both enables come from one flop so they always agree
    assign mem_ce1_n = ~sel;
    assign mem_ce2   = sel;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int WP_CYC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    logic       chip_on;
    logic [7:0] low_run_q;

    assign chip_on = !mem_ce1_n && mem_ce2;

    // length of the current write-enable low run, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (mem_we_n) begin
            low_run_q <= '0;
        end else if (low_run_q != 8'hFF) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    a_r1_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);

    a_r2_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && chip_on));

    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && chip_on));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (low_run_q >= 8'(WP_CYC)));

    a_r4_driver_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && chip_on));

    a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    a_r4_driver_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_on && $past(chip_on)) |-> $stable(mem_addr));

    a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !chip_on);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW), .WP_CYC(WP_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int CLK    = 10;
    localparam int TRC    = 55;
    localparam int TAA    = 55;
    localparam int TWC    = 55;
    localparam int TWP    = 40;
    localparam int TDS    = 25;

    function automatic int up(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R7: expected latency, counted in sampling points after the accept edge
    localparam int EXP_RD = mx(up(TRC), up(TAA));
    localparam int EXP_WP = mx(mx(up(TWP), up(TDS)), mx(up(TWC) - 2, 1));
    localparam int LAT_RD = EXP_RD + 1;
    localparam int LAT_WR = EXP_WP + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;

    always #(CLK/2) clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit run_done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM with timing rules ----------------
    bit [7:0] ram [bit [16:0]];
    bit [7:0] shadow [bit [16:0]];

    function automatic bit [7:0] fill(input bit [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
    endfunction

    int          sel_n = 0, wl_n = 0, ds_n = 0, rd_n = 0, viol = 0;
    logic        prev_sel = 0, prev_wl = 0, prev_oe = 0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0, wr_byte = '0;

    always @(negedge clk) begin
        logic s, wl;
        if (rst_n) begin
            s  = !mem_ce1_n && mem_ce2;
            wl = s && !mem_we_n;
            if (s && prev_sel && mem_addr != prev_addr) begin
                viol++; $display("FAIL R5 address moved while selected actual=%0h expected=%0h", mem_addr, prev_addr);
            end
            if (wl && !mem_oe_n) begin
                viol++; $display("FAIL R3 output enable low in write actual=0 expected=1");
            end
            if (mem_dq_oe && (!mem_oe_n || !s)) begin
                viol++; $display("FAIL R4 driver on outside write actual=1 expected=0");
            end
            if (prev_wl && !wl) begin
                if (wl_n * CLK < TWP) begin
                    viol++; $display("FAIL R3 pulse too short actual=%0d expected=%0d", wl_n * CLK, TWP);
                end
                if (ds_n * CLK < TDS) begin
                    viol++; $display("FAIL R4 data setup short actual=%0d expected=%0d", ds_n * CLK, TDS);
                end
                ram[prev_addr] = wr_byte;
                wl_n = 0;
            end
            if (wl) begin
                wl_n++;
                wr_byte = mem_dq_o;
                if (!mem_dq_oe) begin
                    viol++; $display("FAIL R4 data not driven during pulse actual=0 expected=1");
                end
            end
            if (mem_dq_oe) ds_n = (prev_oe && mem_dq_o == prev_dq) ? ds_n + 1 : 1;
            else ds_n = 0;
            if (s) sel_n++;
            else if (prev_sel) begin
                if (sel_n * CLK < mx(TRC, TWC)) begin
                    viol++; $display("FAIL R7 cycle too short actual=%0d expected=%0d", sel_n * CLK, mx(TRC, TWC));
                end
                sel_n = 0;
            end
            if (s && !mem_oe_n && mem_we_n && !(prev_sel && mem_addr != prev_addr)) rd_n++;
            else rd_n = 0;
            if (rd_n > 0 && rd_n * CLK - CLK / 2 >= TAA)
                mem_dq_i = ram.exists(mem_addr) ? ram[mem_addr] : fill(mem_addr);
            else
                mem_dq_i = 8'hEE;
            prev_sel  = s;
            prev_wl   = wl;
            prev_oe   = mem_dq_oe;
            prev_addr = mem_addr;
            prev_dq   = mem_dq_o;
        end
    end

    function automatic bit [7:0] expect_rd(input bit [16:0] a);
        return shadow.exists(a) ? shadow[a] : fill(a);
    endfunction

    // one request, returning read byte and latency
    task automatic issue(input bit wr, input bit [16:0] a, input bit [7:0] d,
                         output bit [7:0] rd, output int lat);
        bit got;
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) shadow[a] = d;
        lat = 0;
        got = 0;
        while (!got && lat < 60) begin
            @(negedge clk);
            lat++;
            if (lat == 1) chk(req_ready == 1'b0, "R6 ready low while busy", req_ready, 0);
            if (rsp_valid) got = 1;
        end
        rd = rsp_rdata;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R6 response lasts one cycle", rsp_valid, 0);
        chk(req_ready == 1'b1, "R6 ready back after response", req_ready, 1);
    endtask

    typedef struct packed {
        bit        wr;
        bit [16:0] addr;
        bit [7:0]  data;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b0, 17'h00000, 8'h00},
        '{1'b1, 17'h1FFFF, 8'h3C},
        '{1'b0, 17'h1FFFF, 8'h00},
        '{1'b0, 17'h12345, 8'h00},
        '{1'b1, 17'h12345, 8'h00},
        '{1'b0, 17'h12345, 8'h00},
        '{1'b1, 17'h12345, 8'hFF},
        '{1'b0, 17'h12345, 8'h00},
        '{1'b1, 17'h0AAAA, 8'h55},
        '{1'b0, 17'h0AAAA, 8'h00},
        '{1'b0, 17'h15555, 8'h00}
    };

    initial begin
        #2_000_000;
        if (!run_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit [7:0] rd;
        int lat;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_ce1_n == 1'b1, "R1 ce1_n in reset", mem_ce1_n, 1);
        chk(mem_ce2 == 1'b0, "R1 ce2 in reset", mem_ce2, 0);
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes in reset", {mem_oe_n, mem_we_n}, 3);
        chk(mem_dq_oe == 1'b0, "R1 driver off in reset", mem_dq_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, "R1 idle deselected", {mem_ce1_n, mem_ce2}, 2);

        // R2 R3 R7 R8: vector walk
        foreach (VECS[i]) begin
            issue(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, lat);
            if (VECS[i].wr) begin
                chk(lat == LAT_WR, "R3 R7 write latency", lat, LAT_WR);
            end else begin
                chk(lat == LAT_RD, "R2 R7 read latency", lat, LAT_RD);
                chk(rd == expect_rd(VECS[i].addr), "R2 R8 read data", rd, expect_rd(VECS[i].addr));
            end
        end

        // R5: request held during a busy write is ignored
        @(negedge clk);
        req_valid = 1'b1; req_wr = 1'b1; req_addr = 17'h00777; req_wdata = 8'h11;
        @(posedge clk);
        #1;
        shadow[17'h00777] = 8'h11;
        req_addr = 17'h00888; req_wdata = 8'h22;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R5 busy refuses request", req_ready, 0);
        end
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
        chk(mem_ce1_n == 1'b1, "R5 no second access started", mem_ce1_n, 1);
        issue(1'b0, 17'h00888, 8'h00, rd, lat);
        chk(rd == fill(17'h00888), "R5 ignored write left location", rd, fill(17'h00888));
        issue(1'b0, 17'h00777, 8'h00, rd, lat);
        chk(rd == 8'h11, "R5 accepted write landed", rd, 8'h11);

        // R8: back-to-back with data 00 at top address, then read
        issue(1'b1, 17'h1FFFF, 8'h00, rd, lat);
        issue(1'b0, 17'h1FFFF, 8'h00, rd, lat);
        chk(rd == 8'h00, "R8 zero byte at top address", rd, 8'h00);

        repeat (3) @(negedge clk);
        chk(viol == 0, "R3 R4 R5 R7 memory model timing rules", viol, 0);
        run_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule